// File: doc/BRIEF.md
# Flash Write Protection Controller

This block owns the status byte of a serial flash and rules on every decoded command, before the program/erase engine gets it. For each command strobe it combines the write-enable latch, the hardware lock on the status byte (the lock bit together with the write-protect pin level), the block-protection address decode and the busy state. The result is a single grant or deny pulse. The engine acts only on a grant, and it reports completion with a one-cycle done pulse.

The array has four equal blocks. `ADDR_W` = 17 gives a 128 KB array and 18 gives a 256 KB array. Protection regions are whole quarters of the array, so the decision uses only the two top address bits. The serial front end shifts the command in and hands over the opcode, the address, the first data byte and a flag. The flag is high when the chip select was released on a byte boundary. All pins are plain control and status signals: there is no data stream and no back-pressure. A command is a single-cycle strobe and cannot be stalled, and the decision appears exactly one clock later.

Top module: `flash_wprot_ctrl`

## Requirements
- R1: After reset the status byte reads 00h. Bit 7 is the lock bit, bits 6:5 always read 0, bits 4:2 hold the protection field P2..P0, bit 1 is the write-enable latch and bit 0 is the busy flag.
- R2: Opcode 06h sets the write-enable latch and opcode 04h clears it. Both are granted when the block is not busy.
- R3: The write-class opcodes are 01h (status write), 02h (program), 20h/D7h (4 KB sector erase), D8h (block erase) and C7h/60h (chip erase). Each of them is denied when the write-enable latch is 0.
- R4: A status write is denied when bit 7 is 1 and `wp_n` is 0, and accepted in the other three combinations. An accepted status write loads data bits 7 and 4:2 and ignores data bits 6:5 and 1:0.
- R5: For 02h, 20h, D7h and D8h the quarter index is address bits [ADDR_W-1:ADDR_W-2]. Protection field bits P1:P0 decide the denial: 00 denies no quarter, 01 denies quarter 3, 10 denies quarters 2 and 3, and 11 denies all quarters. P2 does not enter this decode.
- R6: Chip erase is granted only when P2..P0 are all 0.
- R7: An accepted write-class command sets the busy flag in the cycle after the strobe, and the write-enable latch stays set. A done pulse clears both the busy flag and the write-enable latch.
- R8: While the busy flag is 1, every opcode except 05h (status read) is denied. Opcode 05h is always granted.
- R9: A write-class command with `cmd_aligned` low is denied.
- R10: Each strobe produces exactly one of `grant` or `deny`, one cycle later. Neither output pulses in any other cycle.
- R11: A denied command leaves the whole status byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Single-cycle command strobe |
| cmd_op | input | 8 | Decoded opcode |
| cmd_addr | input | ADDR_W | Target byte address |
| cmd_data | input | 8 | First data byte (used by status write) |
| cmd_aligned | input | 1 | Chip select released on a byte boundary |
| wp_n | input | 1 | Write-protect pin level |
| eng_done | input | 1 | Engine finished the running operation |
| grant | output | 1 | Command accepted (one cycle after the strobe) |
| deny | output | 1 | Command rejected (one cycle after the strobe) |
| status | output | 8 | Status byte |

## Verification
The assertions take for granted that `eng_done` pulses only while the busy flag is set and that `cmd_valid` is a one-cycle strobe. A command and a done pulse never share a cycle. The bench drives every input on the falling edge and sends each done pulse alone, only after a write-class grant. It holds `wp_n` steady across each status-write command.

// File: rtl/fwp_pkg.sv
package fwp_pkg;
  typedef enum logic [2:0] {
    K_OTHER, K_RDSR, K_WREN, K_WRDI, K_WRSR, K_ADDR, K_CHIP
  } cmd_kind_e;

  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_SEC_A = 8'h20;
  localparam logic [7:0] OP_SEC_B = 8'hD7;
  localparam logic [7:0] OP_BLK   = 8'hD8;
  localparam logic [7:0] OP_CHP_A = 8'hC7;
  localparam logic [7:0] OP_CHP_B = 8'h60;
endpackage

// File: rtl/fwp_decode.sv
module fwp_decode
  import fwp_pkg::*;
(
  input  logic [7:0] op,
  output cmd_kind_e  kind
);
  always_comb begin
    unique case (op)
      OP_RDSR:                    kind = K_RDSR;
      OP_WREN:                    kind = K_WREN;
      OP_WRDI:                    kind = K_WRDI;
      OP_WRSR:                    kind = K_WRSR;
      OP_PROG, OP_SEC_A,
      OP_SEC_B, OP_BLK:           kind = K_ADDR;
      OP_CHP_A, OP_CHP_B:         kind = K_CHIP;
      default:                    kind = K_OTHER;
    endcase
  end
endmodule

// File: rtl/fwp_region.sv
module fwp_region #(
  parameter int ADDR_W = 17
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        prot,
  output logic              hit
);
  localparam int Q_LSB = ADDR_W - 2;
  logic [1:0] quarter;
  assign quarter = addr[ADDR_W-1:Q_LSB];

  always_comb begin
    unique case (prot)
      2'b00: hit = 1'b0;
      2'b01: hit = (quarter == 2'b11);
      2'b10: hit = quarter[1];
      default: hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/fwp_status.sv
module fwp_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_wel,
  input  logic       clr_wel,
  input  logic       load_sr,
  input  logic [7:0] sr_data,
  input  logic       start_wip,
  input  logic       eng_done,
  output logic       lock_q,
  output logic [2:0] prot_q,
  output logic       wel_q,
  output logic       wip_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      prot_q <= '0;
      wel_q  <= 1'b0;
      wip_q  <= 1'b0;
    end else begin
      if (load_sr) begin
        lock_q <= sr_data[7];
        prot_q <= sr_data[4:2];
      end
      if (set_wel)   wel_q <= 1'b1;
      if (clr_wel)   wel_q <= 1'b0;
      if (start_wip) wip_q <= 1'b1;
      if (eng_done) begin
        wip_q <= 1'b0;
        wel_q <= 1'b0;
      end
    end
  end

  // R7
  wip_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip_q) |-> ($past(eng_done) && !wel_q));
endmodule

// File: rtl/flash_wprot_ctrl.sv
module flash_wprot_ctrl
  import fwp_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  input  logic              cmd_aligned,
  input  logic              wp_n,
  input  logic              eng_done,
  output logic              grant,
  output logic              deny,
  output logic [7:0]        status
);
  cmd_kind_e  kind;
  logic       hit;
  logic       lock_q, wel_q, wip_q;
  logic [2:0] prot_q;
  logic       ok, take, is_wr;

  fwp_decode u_dec (.op(cmd_op), .kind(kind));

  fwp_region #(.ADDR_W(ADDR_W)) u_reg (
    .addr(cmd_addr), .prot(prot_q[1:0]), .hit(hit));

  assign is_wr = (kind == K_WRSR) || (kind == K_ADDR) || (kind == K_CHIP);

  always_comb begin
    unique case (kind)
      K_RDSR:  ok = 1'b1;
      K_WRSR:  ok = !wip_q && wel_q && cmd_aligned && !(lock_q && !wp_n);
      K_ADDR:  ok = !wip_q && wel_q && cmd_aligned && !hit;
      K_CHIP:  ok = !wip_q && wel_q && cmd_aligned && (prot_q == 3'b000);
      default: ok = !wip_q;
    endcase
  end

  assign take = cmd_valid && ok;

  fwp_status u_st (
    .clk(clk), .rst_n(rst_n),
    .set_wel(take && kind == K_WREN),
    .clr_wel(take && kind == K_WRDI),
    .load_sr(take && kind == K_WRSR),
    .sr_data(cmd_data),
    .start_wip(take && is_wr),
    .eng_done(eng_done),
    .lock_q(lock_q), .prot_q(prot_q), .wel_q(wel_q), .wip_q(wip_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant <= 1'b0;
      deny  <= 1'b0;
    end else begin
      grant <= take;
      deny  <= cmd_valid && !ok;
    end
  end

  assign status = {lock_q, 2'b00, prot_q, wel_q, wip_q};

  // R10
  one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> (grant ^ deny));
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> (!grant && !deny));
  // R8
  busy_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && status[0] && cmd_op != OP_RDSR) |=> deny);
  // R3
  wel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && is_wr && !status[1]) |=> deny);
  // R6
  chip_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && kind == K_CHIP && status[4:2] != 3'b000) |=> deny);
  // R11
  deny_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (deny && !$past(eng_done)) |-> $stable(status));
endmodule

// File: tb/flash_wprot_ctrl_tb_top.sv
module flash_wprot_ctrl_tb_top;
  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [7:0]    cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [7:0]    cmd_data = '0;
  logic          cmd_aligned = 1'b1;
  logic          wp_n = 1'b1;
  logic          eng_done = 1'b0;
  logic          grant, deny;
  logic [7:0]    status;

  always #2 clk = ~clk;

  flash_wprot_ctrl #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_aligned(cmd_aligned),
    .wp_n(wp_n), .eng_done(eng_done), .grant(grant), .deny(deny),
    .status(status));

  int n_vec = 0;
  int n_bad = 0;
  logic       m_lock = 0, m_wel = 0, m_wip = 0;
  logic [2:0] m_prot = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] m_stat();
    return {m_lock, 2'b00, m_prot, m_wel, m_wip};
  endfunction

  function automatic logic is_wr(input logic [7:0] op);
    return op inside {8'h01, 8'h02, 8'h20, 8'hD7, 8'hD8, 8'hC7, 8'h60};
  endfunction

  function automatic logic m_ok(input logic [7:0] op, input logic [AW-1:0] a, input logic al);
    logic [1:0] q;
    q = a[AW-1:AW-2];
    if (op == 8'h05) return 1'b1;
    if (m_wip) return 1'b0;
    if (!is_wr(op)) return 1'b1;
    if (!al || !m_wel) return 1'b0;
    if (op == 8'h01) return !(m_lock && !wp_n);
    if (op == 8'hC7 || op == 8'h60) return m_prot == 3'b000;
    case (m_prot[1:0])
      2'b00: return 1'b1;
      2'b01: return q != 2'd3;
      2'b10: return q < 2'd2;
      default: return 1'b0;
    endcase
  endfunction

  task automatic run(input string req, input logic [7:0] op, input logic [AW-1:0] a,
                     input logic [7:0] d, input logic al);
    logic ok;
    ok = m_ok(op, a, al);
    @(negedge clk);
    cmd_op = op; cmd_addr = a; cmd_data = d; cmd_aligned = al; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(req, {grant, deny}, {ok, !ok});
    if (ok) begin
      if (op == 8'h06) m_wel = 1'b1;
      if (op == 8'h04) m_wel = 1'b0;
      if (op == 8'h01) begin m_lock = d[7]; m_prot = d[4:2]; end
      if (is_wr(op)) m_wip = 1'b1;
    end
    chk(req, status, m_stat());
  endtask

  task automatic finish_op();
    if (m_wip) begin
      @(negedge clk); eng_done = 1'b1;
      @(negedge clk); eng_done = 1'b0;
      m_wip = 1'b0; m_wel = 1'b0;
      chk("R7", status, m_stat());
      chk("R10", {grant, deny}, 2'b00);
    end
  endtask

  task automatic set_prot(input logic [2:0] p);
    run("R2", 8'h06, '0, 8'h00, 1'b1);
    run("R4", 8'h01, '0, {3'b000, p, 2'b00}, 1'b1);
    finish_op();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL R10 watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] ops[4];
    logic [7:0] wops[7];
    ops = '{8'h02, 8'h20, 8'hD7, 8'hD8};
    wops = '{8'h01, 8'h02, 8'h20, 8'hD7, 8'hD8, 8'hC7, 8'h60};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", status, 8'h00);
    chk("R10", {grant, deny}, 2'b00);

    // R2 latch set/clear
    run("R2", 8'h06, '0, 8'h00, 1'b1);
    run("R2", 8'h04, '0, 8'h00, 1'b1);
    run("R2", 8'h06, '0, 8'h00, 1'b1);
    run("R2", 8'h03, '0, 8'h00, 1'b1);
    run("R2", 8'h04, '0, 8'h00, 1'b1);

    // R3 and R11: write-class with latch clear
    for (int i = 0; i < 7; i++) run("R3", wops[i], '0, 8'h9C, 1'b1);

    // R5 and R6: quarter decode for every protection field value
    for (int p = 0; p < 8; p++) begin
      set_prot(3'(p));
      for (int o = 0; o < 4; o++)
        for (int q = 0; q < 4; q++)
          for (int w = 0; w < 2; w++) begin
            if (w == 1) run("R2", 8'h06, '0, 8'h00, 1'b1);
            else        run("R2", 8'h04, '0, 8'h00, 1'b1);
            run("R5", ops[o], {2'(q), 15'(13'h1A5 * (o + 1) + q)}, 8'h00, 1'b1);
            finish_op();
          end
      run("R2", 8'h06, '0, 8'h00, 1'b1);
      run("R6", 8'hC7, '0, 8'h00, 1'b1);
      finish_op();
      run("R2", 8'h06, '0, 8'h00, 1'b1);
      run("R6", 8'h60, '0, 8'h00, 1'b1);
      finish_op();
    end

    // R4: lock bit against pin level, reserved data bits ignored
    for (int l = 0; l < 2; l++)
      for (int w = 0; w < 2; w++) begin
        wp_n = 1'b1;
        run("R4", 8'h06, '0, 8'h00, 1'b1);
        run("R4", 8'h01, '0, {1'(l), 7'h00}, 1'b1);
        finish_op();
        wp_n = 1'(w);
        run("R4", 8'h06, '0, 8'h00, 1'b1);
        run("R4", 8'h01, '0, 8'h7F, 1'b1);
        finish_op();
        wp_n = 1'b1;
      end
    run("R1", 8'h06, '0, 8'h00, 1'b1);
    run("R1", 8'h01, '0, 8'h63, 1'b1);
    finish_op();
    chk("R1", status, 8'h00);

    // R9: unaligned write-class commands
    run("R9", 8'h06, '0, 8'h00, 1'b1);
    for (int i = 0; i < 7; i++) run("R9", wops[i], '0, 8'h00, 1'b0);

    // R8: busy window
    run("R8", 8'h02, 17'h00123, 8'h00, 1'b1);
    run("R8", 8'h06, '0, 8'h00, 1'b1);
    run("R8", 8'h04, '0, 8'h00, 1'b1);
    run("R8", 8'h03, '0, 8'h00, 1'b1);
    run("R8", 8'h01, '0, 8'h1C, 1'b1);
    run("R8", 8'hC7, '0, 8'h00, 1'b1);
    run("R8", 8'h05, '0, 8'h00, 1'b1);
    run("R8", 8'h05, '0, 8'h00, 1'b0);
    finish_op();
    run("R8", 8'h05, '0, 8'h00, 1'b1);

    // R11: denied command with latch set keeps it set
    set_prot(3'b011);
    run("R11", 8'h06, '0, 8'h00, 1'b1);
    run("R11", 8'hD8, 17'h00010, 8'h00, 1'b1);
    run("R11", 8'h60, '0, 8'h00, 1'b1);

    @(negedge clk);
    chk("R10", {grant, deny}, 2'b00);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule